// File: doc/BRIEF.md
# Pin Bank with Latched Interrupt Triggers

A bank of sixteen general-purpose pins with a word-wide register port. For each pin, software chooses whether the chip drives it, which value is driven, and whether an alternate peripheral owns it. Each pin also has its own interrupt trigger. The trigger is either a level (high or low) or a single edge (rising or falling). The bank samples the raw pin levels through a two-flop synchroniser. Software can read those sampled levels back. Every trigger hit is latched in an event register, and the bank raises one summary interrupt when any latched event is not masked.

Software clears events by writing the event register. A bit written as 0 clears that event and a bit written as 1 keeps it, so writing all zeros clears everything. To catch both edges, software flips a pin's edge-polarity bit after each event. Flipping the bit never creates an event by itself. The register port is a plain single-cycle write strobe with a combinational read. No data stream crosses the block, so no valid/ready handshake or back-pressure applies.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register addresses are: 0 direction, 1 output value, 2 alternate select, 3 interrupt mask, 4 trigger kind, 5 edge polarity, 6 level polarity, 7 pin level (read-only), 8 event. After reset, direction, output value, alternate select and event read 0. Mask, trigger kind, edge polarity and level polarity read 16'hFFFF. `irq` is 0 while the pins are held low.
- R2: Direction, output value and alternate select read back as written. They drive `pin_oe` (1 = output), `pin_o` and `alt_sel` bit for bit.
- R3: The pin-level register returns `pin_i` through two flops. A change driven between edges is not yet visible after the first rising clock edge and is visible after the second.
- R4: With the trigger-kind bit at 1 (edge), a pin latches its event bit on a rising sampled transition when its edge-polarity bit is 1, and on a falling one when it is 0. The opposite transition latches nothing. Latched bits stay set until cleared.
- R5: With the trigger-kind bit at 0 (level), a pin latches its event bit while its sampled level equals its level-polarity bit (1 = high, 0 = low). The bit sets again in the cycle after any clear for as long as that level persists.
- R6: A write to the event register keeps the bits written as 1 and clears the bits written as 0. A trigger hit in the same cycle as the write sets its bit regardless.
- R7: Rewriting an edge-polarity bit while the pin is stable latches no event. The next transition in the new direction is latched.
- R8: `irq` is 1 exactly when some event bit is set and its mask bit is 0. Masking blocks only `irq`; the event bit still latches.
- R9: Writes to the pin-level register have no effect. Reading an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw pin levels, asynchronous |
| pin_o | output | 16 | Output value for pins that are outputs |
| pin_oe | output | 16 | Output enable per pin |
| alt_sel | output | 16 | Alternate-function select per pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Summary interrupt |

## Verification
The hardest case to reach is a clear written in the same clock as a new trigger hit. The bench gets there by counting the two synchroniser edges after a pin change and placing the write strobe exactly on the edge that latches the hit. It then expects the fresh bit to survive while older bits are cleared. The both-edge procedure is reached by flipping the polarity on a settled high pin and checking that nothing is latched before the falling edge. A sweep over every pin and all four trigger settings covers the level re-set after a clear and the rejection of the opposite edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR   = 4'd0,
    RA_DOUT  = 4'd1,
    RA_ALT   = 4'd2,
    RA_MASK  = 4'd3,
    RA_KIND  = 4'd4,
    RA_EPOL  = 4'd5,
    RA_LPOL  = 4'd6,
    RA_LEVEL = 4'd7,
    RA_EVENT = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign cur_o  = stg[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = cur[i] & ~prev[i];
    assign fall     = ~cur[i] & prev[i];
    assign edge_hit = epol[i] ? rise : fall;
    assign lvl_hit  = (cur[i] == lpol[i]);
    assign hit[i]   = kind[i] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      alt_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      kind_q,
  output logic [W-1:0]      epol_q,
  output logic [W-1:0]      lpol_q
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      alt_q  <= '0;
      mask_q <= '1;
      kind_q <= '1;
      epol_q <= '1;
      lpol_q <= '1;
    end else if (we) begin
      case (sel)
        RA_DIR:  dir_q  <= wdata;
        RA_DOUT: dout_q <= wdata;
        RA_ALT:  alt_q  <= wdata;
        RA_MASK: mask_q <= wdata;
        RA_KIND: kind_q <= wdata;
        RA_EPOL: epol_q <= wdata;
        RA_LPOL: lpol_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  alt_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq
);
  logic [NPINS-1:0] dir_q, dout_q, alt_q, mask_q, kind_q, epol_q, lpol_q;
  logic [NPINS-1:0] pin_sync, pin_prev, hit_w, evt_q;
  logic             evt_wr;

  gpio_bank_regs #(.W(NPINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .dir_q  (dir_q),
    .dout_q (dout_q),
    .alt_q  (alt_q),
    .mask_q (mask_q),
    .kind_q (kind_q),
    .epol_q (epol_q),
    .lpol_q (lpol_q)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_i),
    .cur_o  (pin_sync),
    .prev_o (pin_prev)
  );

  gpio_event_detect #(.W(NPINS)) u_detect (
    .cur  (pin_sync),
    .prev (pin_prev),
    .kind (kind_q),
    .epol (epol_q),
    .lpol (lpol_q),
    .hit  (hit_w)
  );

  assign evt_wr = reg_we && (reg_addr_e'(reg_addr) == RA_EVENT);

  // Clear-by-zero write; a hit in the same cycle wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_wr ? (evt_q & reg_wdata) : evt_q) | hit_w;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_DIR:   reg_rdata = dir_q;
      RA_DOUT:  reg_rdata = dout_q;
      RA_ALT:   reg_rdata = alt_q;
      RA_MASK:  reg_rdata = mask_q;
      RA_KIND:  reg_rdata = kind_q;
      RA_EPOL:  reg_rdata = epol_q;
      RA_LPOL:  reg_rdata = lpol_q;
      RA_LEVEL: reg_rdata = pin_sync;
      RA_EVENT: reg_rdata = evt_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign pin_o   = dout_q;
  assign pin_oe  = dir_q;
  assign alt_sel = alt_q;
  assign irq     = |(evt_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NPINS-1:0]  reg_wdata,
  input logic              irq,
  input logic [NPINS-1:0]  evt_q,
  input logic [NPINS-1:0]  hit_w,
  input logic [NPINS-1:0]  kind_q,
  input logic [NPINS-1:0]  pin_sync,
  input logic [NPINS-1:0]  pin_prev
);
  // R4: latched events persist unless the event register is written
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RA_EVENT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R6: after a clear write only kept bits or new hits remain
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_EVENT) |=> ((evt_q & ~($past(reg_wdata) | $past(hit_w))) == '0));

  // R6: a hit always lands in the event register
  a_r6_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w != '0) |=> ((evt_q & $past(hit_w)) == $past(hit_w)));

  // R7: an edge-mode pin with a stable sample never produces a hit
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_w & kind_q & ~(pin_sync ^ pin_prev)) == '0));

  // R8: the summary interrupt needs a latched event
  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .evt_q     (evt_q),
  .hit_w     (hit_w),
  .kind_q    (kind_q),
  .pin_sync  (pin_sync),
  .pin_prev  (pin_prev)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  localparam logic [3:0] A_DIR = 4'd0, A_DOUT = 4'd1, A_ALT = 4'd2, A_MASK = 4'd3,
                         A_KIND = 4'd4, A_EPOL = 4'd5, A_LPOL = 4'd6, A_LEVEL = 4'd7,
                         A_EVENT = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_o, pin_oe, alt_sel, reg_rdata;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(3);
    // R1 reset state
    rd(A_DIR, v);   chk("R1 dir", v, 16'h0000);
    rd(A_DOUT, v);  chk("R1 dout", v, 16'h0000);
    rd(A_ALT, v);   chk("R1 alt", v, 16'h0000);
    rd(A_MASK, v);  chk("R1 mask", v, 16'hFFFF);
    rd(A_KIND, v);  chk("R1 kind", v, 16'hFFFF);
    rd(A_EPOL, v);  chk("R1 epol", v, 16'hFFFF);
    rd(A_LPOL, v);  chk("R1 lpol", v, 16'hFFFF);
    rd(A_EVENT, v); chk("R1 event", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 pin control
    wr(A_DIR, 16'hA5A5); wr(A_DOUT, 16'h3C3C); wr(A_ALT, 16'h0F0F);
    rd(A_DIR, v);  chk("R2 dir rb", v, 16'hA5A5);
    rd(A_DOUT, v); chk("R2 dout rb", v, 16'h3C3C);
    rd(A_ALT, v);  chk("R2 alt rb", v, 16'h0F0F);
    chk("R2 pin_oe", pin_oe, 16'hA5A5);
    chk("R2 pin_o", pin_o, 16'h3C3C);
    chk("R2 alt_sel", alt_sel, 16'h0F0F);

    // R3 two-flop latency of the level readback
    @(negedge clk); pin_i = 16'h1234;
    @(negedge clk); rd(A_LEVEL, v); chk("R3 one edge", v, 16'h0000);
    @(negedge clk); rd(A_LEVEL, v); chk("R3 two edges", v, 16'h1234);

    // R9 level register is read-only, unmapped reads zero
    wr(A_LEVEL, 16'hFFFF);
    rd(A_LEVEL, v); chk("R9 level ro", v, 16'h1234);
    rd(4'd15, v);   chk("R9 unmapped", v, 16'h0000);
    pin_i = 16'h0000; settle(4); wr(A_EVENT, 16'h0000);

    // R4 R5 sweep over every pin and every trigger setting
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] base, bit_p;
        bit_p = 16'h1 << p;
        base  = (m == 1 || m == 3) ? 16'hFFFF : 16'h0000;
        @(negedge clk); pin_i = base;
        wr(A_KIND, (m < 2) ? 16'hFFFF : 16'h0000);
        wr(A_EPOL, (m == 0) ? 16'hFFFF : 16'h0000);
        wr(A_LPOL, (m == 2) ? 16'hFFFF : 16'h0000);
        settle(4); wr(A_EVENT, 16'h0000); settle(1);
        rd(A_EVENT, v); chk((m < 2) ? "R4 idle" : "R5 idle", v, 16'h0000);
        pin_i = base ^ bit_p;
        settle(4);
        rd(A_EVENT, v); chk((m < 2) ? "R4 active edge" : "R5 active level", v, bit_p);
        if (m < 2) begin
          wr(A_EVENT, 16'h0000);
          pin_i = base; settle(4);
          rd(A_EVENT, v); chk("R4 opposite edge ignored", v, 16'h0000);
        end else begin
          wr(A_EVENT, 16'h0000);
          rd(A_EVENT, v); chk("R5 re-set after clear", v, bit_p);
        end
      end
    end

    // R6 partial clear and clear coinciding with a hit
    @(negedge clk); pin_i = '0;
    wr(A_KIND, 16'hFFFF); wr(A_EPOL, 16'hFFFF);
    settle(4); wr(A_EVENT, 16'h0000);
    @(negedge clk); pin_i = 16'h000F; settle(4);
    rd(A_EVENT, v); chk("R6 setup", v, 16'h000F);
    wr(A_EVENT, 16'h0005);
    rd(A_EVENT, v); chk("R6 keep ones", v, 16'h0005);
    @(negedge clk); pin_i = 16'h008F;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_EVENT; reg_wdata = 16'h0000;
    @(negedge clk); reg_we = 1'b0;
    rd(A_EVENT, v); chk("R6 hit beats clear", v, 16'h0080);

    // R7 polarity flip for both-edge use
    @(negedge clk); pin_i = 16'h0000; settle(4); wr(A_EVENT, 16'h0000);
    @(negedge clk); pin_i = 16'h0020; settle(4);
    rd(A_EVENT, v); chk("R7 rising", v, 16'h0020);
    wr(A_EVENT, 16'h0000);
    wr(A_EPOL, 16'hFFDF); settle(4);
    rd(A_EVENT, v); chk("R7 flip no event", v, 16'h0000);
    pin_i = 16'h0000; settle(4);
    rd(A_EVENT, v); chk("R7 falling caught", v, 16'h0020);

    // R8 mask gates only the summary interrupt
    wr(A_EVENT, 16'h0000);
    @(negedge clk); pin_i = 16'h0004; settle(4);
    rd(A_EVENT, v); chk("R8 latched while masked", v, 16'h0004);
    chk("R8 masked irq", {15'd0, irq}, 16'h0000);
    wr(A_MASK, 16'hFFFB); settle(1);
    chk("R8 unmasked irq", {15'd0, irq}, 16'h0001);
    wr(A_MASK, 16'h0004); settle(1);
    chk("R8 other unmasked", {15'd0, irq}, 16'h0000);
    wr(A_MASK, 16'h0000); wr(A_EVENT, 16'h0000); settle(1);
    chk("R8 cleared irq", {15'd0, irq}, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule